// File: doc/BRIEF.md
# Task Switch Pre-Check Sequencer

This block decides the outcome of a guest's attempt to switch tasks while it runs under a hypervisor. Such a switch is never carried out. Before the hypervisor is handed an exit, the block walks through four check stages in a fixed order. Any stage can end the walk with a fault. An exit is requested only when every stage passes. The caller gives one attempt as a request beat. That beat describes what started the switch, the processor mode, the nested-task flag, and pass/fail results already computed for the gate, the selector and the descriptor. Privilege arithmetic happens outside the block; it only sees the pass/fail results.

The rules for stage 1 depend on the source of the switch and on whether 64-bit mode is active. Some sources skip privilege checks and others do not. In 64-bit mode every real attempt faults. Stages 2 to 4 check the selector limit, then the descriptor read, then the descriptor attributes.

The request side uses valid/ready. A beat is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when no attempt is in flight, so the caller simply holds its beat until it is taken. The result side also uses valid/ready. A result stays on the port unchanged until the consumer raises `res_ready`.

Top module: `tsw_check_seq`

## Requirements
- R1: `req_ready` is 1 only while the block is idle. It is 1 after reset and 0 from the cycle after acceptance until the result is taken. All request fields are captured at acceptance; later changes to them have no effect on the result.
- R2: While `res_valid` is 1 and `res_ready` is 0, every result output holds steady. In the cycle after `res_valid` and `res_ready` are both 1, `res_valid` is 0 and `req_ready` is 1.
- R3: With the 64-bit flag set, every task-switch attempt ends at stage 1 with a general-protection fault (code 13). This covers gate use, direct use, interrupt-table delivery and an interrupt return with the nested flag set. The result appears 1 cycle after acceptance.
- R4: Outside 64-bit mode, a call (source 0), jump (1) or software interrupt (2) through a gate works as follows at stage 1. A gate that is not present gives a not-present fault (code 11). Otherwise a failed gate privilege check gives code 13. The descriptor privilege input is ignored.
- R5: Outside 64-bit mode, a direct call or jump (`req_via_gate`=0) gives code 13 at stage 1 if the descriptor privilege check fails. The gate inputs are ignored.
- R6: Outside 64-bit mode, an NMI (5), hardware exception (6) or external interrupt (7) checks only that the gate is present (code 11 if not). Both privilege inputs are ignored. A breakpoint (3) or overflow (4) also checks gate privilege, giving code 13 if it fails.
- R7: An interrupt return (8) with the nested flag set uses the descriptor directly, with no privilege checks. With the nested flag clear it is not a task switch: after 1 cycle it completes with `res_fault`=0, `res_exit`=0 and code 0, in either mode.
- R8: Stage 2 gives code 13 if the selector is outside the table limit. The result appears 2 cycles after acceptance.
- R9: Stage 3 gives a page fault (code 14) if the descriptor read faulted. This takes priority over any stage-4 problem, and the result appears 3 cycles after acceptance.
- R10: Stage 4 checks, in this order: a bad type gives 13; then a non-present descriptor gives 11; then a wrong system bit or a bad limit gives 13. The result appears 4 cycles after acceptance.
- R11: An exit (`res_exit`=1) is given only when all four stages pass. It appears 4 cycles after acceptance, with `res_fault`=0, code 0 and `res_intinfo_valid`=0.
- R12: `res_vect_valid` is 1 exactly for interrupt-table sources (2 to 7), and `res_vect_vector` then carries the captured vector. `res_intinfo_valid` equals `res_fault`.
- R13: For a task-switch attempt, exactly one of `res_fault` and `res_exit` is 1. The internal one-hot stage state always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Attempt beat present |
| req_ready | output | 1 | Block idle, beat accepted |
| req_src | input | 4 | Source: 0 call, 1 jump, 2 sw interrupt, 3 breakpoint, 4 overflow, 5 NMI, 6 hw exception, 7 ext interrupt, 8 interrupt return |
| req_via_gate | input | 1 | Call/jump goes through a gate (1) or direct (0) |
| req_long_mode | input | 1 | 64-bit mode active |
| req_nested | input | 1 | Nested-task flag |
| req_gate_present | input | 1 | Gate present bit |
| req_gate_priv_ok | input | 1 | Gate privilege check passes |
| req_desc_priv_ok | input | 1 | Descriptor privilege check passes |
| req_sel_in_limit | input | 1 | Selector inside table limit |
| req_read_pf | input | 1 | Descriptor read page-faulted |
| req_type_ok | input | 1 | Descriptor type valid |
| req_desc_present | input | 1 | Descriptor present bit |
| req_sys_ok | input | 1 | Descriptor system bit valid |
| req_limit_ok | input | 1 | Descriptor limit valid |
| req_vector | input | 8 | Vector of the delivering event |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_fault | output | 1 | Attempt ended in a fault |
| res_exit | output | 1 | Exit requested |
| res_code | output | 8 | Fault vector (11, 13, 14) or 0 |
| res_intinfo_valid | output | 1 | Interruption-information valid bit |
| res_vect_valid | output | 1 | Vectoring record valid |
| res_vect_vector | output | 8 | Vector to record |

## Verification
A stage register that skips or repeats a step shows up at the ports as a wrong latency. The bench measures the cycles from acceptance to `res_valid`, and each stage has its own expected value, from 1 to 4. A wrong ordering between stages shows up as the wrong fault code: the bench raises several failures at once and checks which one wins. Because the bench inverts every request field right after acceptance, a capture register that still follows its live input gives a wrong outcome in the same attempt. A result register that is not held shows as changed outputs during a back-pressure stall.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [3:0] {
    SRC_CALL  = 4'd0,
    SRC_JMP   = 4'd1,
    SRC_SWINT = 4'd2,
    SRC_BP    = 4'd3,
    SRC_OF    = 4'd4,
    SRC_NMI   = 4'd5,
    SRC_HWEXC = 4'd6,
    SRC_EXTINT= 4'd7,
    SRC_IRET  = 4'd8
  } tsw_src_e;

  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_GATE = 6'b000010,
    ST_SEL  = 6'b000100,
    ST_READ = 6'b001000,
    ST_ATTR = 6'b010000,
    ST_DONE = 6'b100000
  } tsw_state_e;

  typedef enum logic [1:0] {
    VD_PASS  = 2'd0,
    VD_FAULT = 2'd1,
    VD_NONE  = 2'd2
  } tsw_verdict_e;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_NONE = 8'd0;
  localparam logic [CODE_W-1:0] CODE_NP   = 8'd11;
  localparam logic [CODE_W-1:0] CODE_GP   = 8'd13;
  localparam logic [CODE_W-1:0] CODE_PF   = 8'd14;

  function automatic logic from_idt(input tsw_src_e s);
    return (s == SRC_SWINT) || (s == SRC_BP) || (s == SRC_OF) ||
           (s == SRC_NMI) || (s == SRC_HWEXC) || (s == SRC_EXTINT);
  endfunction

endpackage

// File: rtl/tsw_entry_rules.sv
module tsw_entry_rules
  import tsw_pkg::*;
(
  input  tsw_src_e           src,
  input  logic               via_gate,
  input  logic               long_mode,
  input  logic               nested,
  input  logic               gate_present,
  input  logic               gate_priv_ok,
  input  logic               desc_priv_ok,
  output tsw_verdict_e       verdict,
  output logic [CODE_W-1:0]  code
);

  always_comb begin
    verdict = VD_PASS;
    code    = CODE_NONE;
    if (src == SRC_IRET && !nested) begin
      verdict = VD_NONE;
    end else if (long_mode) begin
      verdict = VD_FAULT;
      code    = CODE_GP;
    end else begin
      case (src)
        SRC_CALL, SRC_JMP: begin
          if (via_gate) begin
            if (!gate_present) begin
              verdict = VD_FAULT; code = CODE_NP;
            end else if (!gate_priv_ok) begin
              verdict = VD_FAULT; code = CODE_GP;
            end
          end else if (!desc_priv_ok) begin
            verdict = VD_FAULT; code = CODE_GP;
          end
        end
        SRC_SWINT, SRC_BP, SRC_OF: begin
          if (!gate_present) begin
            verdict = VD_FAULT; code = CODE_NP;
          end else if (!gate_priv_ok) begin
            verdict = VD_FAULT; code = CODE_GP;
          end
        end
        SRC_NMI, SRC_HWEXC, SRC_EXTINT: begin
          if (!gate_present) begin
            verdict = VD_FAULT; code = CODE_NP;
          end
        end
        SRC_IRET: verdict = VD_PASS;
        default: begin
          verdict = VD_FAULT; code = CODE_GP;
        end
      endcase
    end
  end

endmodule

// File: rtl/tsw_desc_rules.sv
module tsw_desc_rules
  import tsw_pkg::*;
(
  input  logic               st_sel,
  input  logic               st_read,
  input  logic               st_attr,
  input  logic               sel_in_limit,
  input  logic               read_pf,
  input  logic               type_ok,
  input  logic               desc_present,
  input  logic               sys_ok,
  input  logic               limit_ok,
  output logic               fail,
  output logic [CODE_W-1:0]  code
);

  always_comb begin
    fail = 1'b0;
    code = CODE_NONE;
    if (st_sel && !sel_in_limit) begin
      fail = 1'b1; code = CODE_GP;
    end
    if (st_read && read_pf) begin
      fail = 1'b1; code = CODE_PF;
    end
    if (st_attr) begin
      if (!type_ok) begin
        fail = 1'b1; code = CODE_GP;
      end else if (!desc_present) begin
        fail = 1'b1; code = CODE_NP;
      end else if (!sys_ok || !limit_ok) begin
        fail = 1'b1; code = CODE_GP;
      end
    end
  end

endmodule

// File: rtl/tsw_check_seq.sv
module tsw_check_seq
  import tsw_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_src,
  input  logic             req_via_gate,
  input  logic             req_long_mode,
  input  logic             req_nested,
  input  logic             req_gate_present,
  input  logic             req_gate_priv_ok,
  input  logic             req_desc_priv_ok,
  input  logic             req_sel_in_limit,
  input  logic             req_read_pf,
  input  logic             req_type_ok,
  input  logic             req_desc_present,
  input  logic             req_sys_ok,
  input  logic             req_limit_ok,
  input  logic [VEC_W-1:0] req_vector,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_fault,
  output logic             res_exit,
  output logic [7:0]       res_code,
  output logic             res_intinfo_valid,
  output logic             res_vect_valid,
  output logic [VEC_W-1:0] res_vect_vector
);

  tsw_state_e        state;
  tsw_src_e          c_src;
  logic              c_gate, c_long, c_nest, c_gpres, c_gpriv, c_dpriv;
  logic              c_sel, c_pf, c_type, c_dpres, c_sys, c_lim;
  logic [VEC_W-1:0]  c_vec;
  logic              f_q, x_q;
  logic [CODE_W-1:0] code_q;

  tsw_verdict_e      ent_verdict;
  logic [CODE_W-1:0] ent_code;
  logic              dsc_fail;
  logic [CODE_W-1:0] dsc_code;

  tsw_entry_rules u_entry (
    .src          (c_src),
    .via_gate     (c_gate),
    .long_mode    (c_long),
    .nested       (c_nest),
    .gate_present (c_gpres),
    .gate_priv_ok (c_gpriv),
    .desc_priv_ok (c_dpriv),
    .verdict      (ent_verdict),
    .code         (ent_code)
  );

  tsw_desc_rules u_desc (
    .st_sel       (state == ST_SEL),
    .st_read      (state == ST_READ),
    .st_attr      (state == ST_ATTR),
    .sel_in_limit (c_sel),
    .read_pf      (c_pf),
    .type_ok      (c_type),
    .desc_present (c_dpres),
    .sys_ok       (c_sys),
    .limit_ok     (c_lim),
    .fail         (dsc_fail),
    .code         (dsc_code)
  );

  // Capture of the attempt on acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_src <= SRC_CALL;
      {c_gate, c_long, c_nest, c_gpres, c_gpriv, c_dpriv} <= '0;
      {c_sel, c_pf, c_type, c_dpres, c_sys, c_lim} <= '0;
      c_vec <= '0;
    end else if (state == ST_IDLE && req_valid) begin
      c_src   <= tsw_src_e'(req_src);
      c_gate  <= req_via_gate;
      c_long  <= req_long_mode;
      c_nest  <= req_nested;
      c_gpres <= req_gate_present;
      c_gpriv <= req_gate_priv_ok;
      c_dpriv <= req_desc_priv_ok;
      c_sel   <= req_sel_in_limit;
      c_pf    <= req_read_pf;
      c_type  <= req_type_ok;
      c_dpres <= req_desc_present;
      c_sys   <= req_sys_ok;
      c_lim   <= req_limit_ok;
      c_vec   <= req_vector;
    end
  end

  // Stage sequencer: one stage per cycle, early exit on a fault
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      f_q    <= 1'b0;
      x_q    <= 1'b0;
      code_q <= CODE_NONE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) state <= ST_GATE;
        ST_GATE: begin
          case (ent_verdict)
            VD_PASS:  state <= ST_SEL;
            VD_FAULT: begin
              state <= ST_DONE; f_q <= 1'b1; x_q <= 1'b0; code_q <= ent_code;
            end
            default: begin
              state <= ST_DONE; f_q <= 1'b0; x_q <= 1'b0; code_q <= CODE_NONE;
            end
          endcase
        end
        ST_SEL, ST_READ, ST_ATTR: begin
          if (dsc_fail) begin
            state <= ST_DONE; f_q <= 1'b1; x_q <= 1'b0; code_q <= dsc_code;
          end else if (state == ST_ATTR) begin
            state <= ST_DONE; f_q <= 1'b0; x_q <= 1'b1; code_q <= CODE_NONE;
          end else if (state == ST_SEL) begin
            state <= ST_READ;
          end else begin
            state <= ST_ATTR;
          end
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready         = (state == ST_IDLE);
  assign res_valid         = (state == ST_DONE);
  assign res_fault         = f_q;
  assign res_exit          = x_q;
  assign res_code          = code_q;
  assign res_intinfo_valid = f_q;
  assign res_vect_valid    = from_idt(c_src);
  assign res_vect_vector   = c_vec;

  // Assertions
  assert_onehot_state_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  assert_fault_exit_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_fault && res_exit));

  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) &&
                                   $stable(res_fault) && $stable(res_exit)));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && req_ready));

  assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  assert_exit_no_intinfo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_exit) |-> (!res_intinfo_valid && res_code == CODE_NONE));

  assert_long_mode_gp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && c_long && !(c_src == SRC_IRET && !c_nest)) |->
      (res_fault && res_code == CODE_GP));

endmodule

// File: tb/tsw_check_seq_tb.sv
module tsw_check_seq_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_src;
  logic       req_via_gate, req_long_mode, req_nested;
  logic       req_gate_present, req_gate_priv_ok, req_desc_priv_ok;
  logic       req_sel_in_limit, req_read_pf, req_type_ok;
  logic       req_desc_present, req_sys_ok, req_limit_ok;
  logic [7:0] req_vector;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic       res_fault, res_exit, res_intinfo_valid, res_vect_valid;
  logic [7:0] res_code, res_vect_vector;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_P/2) clk = ~clk;

  tsw_check_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_via_gate(req_via_gate),
    .req_long_mode(req_long_mode), .req_nested(req_nested),
    .req_gate_present(req_gate_present), .req_gate_priv_ok(req_gate_priv_ok),
    .req_desc_priv_ok(req_desc_priv_ok), .req_sel_in_limit(req_sel_in_limit),
    .req_read_pf(req_read_pf), .req_type_ok(req_type_ok),
    .req_desc_present(req_desc_present), .req_sys_ok(req_sys_ok),
    .req_limit_ok(req_limit_ok), .req_vector(req_vector),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_fault(res_fault), .res_exit(res_exit), .res_code(res_code),
    .res_intinfo_valid(res_intinfo_valid), .res_vect_valid(res_vect_valid),
    .res_vect_vector(res_vect_vector)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_default();
    req_src = 4'd0; req_via_gate = 1'b0; req_long_mode = 1'b0; req_nested = 1'b0;
    req_gate_present = 1'b1; req_gate_priv_ok = 1'b1; req_desc_priv_ok = 1'b1;
    req_sel_in_limit = 1'b1; req_read_pf = 1'b0; req_type_ok = 1'b1;
    req_desc_present = 1'b1; req_sys_ok = 1'b1; req_limit_ok = 1'b1;
    req_vector = 8'h20;
  endtask

  // Submit one attempt, invert all fields after acceptance, check the result.
  task automatic attempt(input string req, input bit e_fault, input bit e_exit,
                         input int e_code, input int e_cyc, input bit e_vv,
                         input int hold);
    logic [7:0] vec;
    int cyc;
    vec = req_vector;
    @(negedge clk);
    chk("R1", "req_ready idle", int'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_src = ~req_src; req_via_gate = ~req_via_gate; req_long_mode = ~req_long_mode;
    req_nested = ~req_nested; req_gate_present = ~req_gate_present;
    req_gate_priv_ok = ~req_gate_priv_ok; req_desc_priv_ok = ~req_desc_priv_ok;
    req_sel_in_limit = ~req_sel_in_limit; req_read_pf = ~req_read_pf;
    req_type_ok = ~req_type_ok; req_desc_present = ~req_desc_present;
    req_sys_ok = ~req_sys_ok; req_limit_ok = ~req_limit_ok; req_vector = ~req_vector;
    chk("R1", "req_ready busy", int'(req_ready), 0);
    cyc = 0;
    while (!res_valid && cyc < 20) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk(req, "latency", cyc, e_cyc);
    chk(req, "res_fault", int'(res_fault), int'(e_fault));
    chk(req, "res_exit", int'(res_exit), int'(e_exit));
    chk(req, "res_code", int'(res_code), e_code);
    chk("R12", "intinfo_valid", int'(res_intinfo_valid), int'(e_fault));
    chk("R12", "vect_valid", int'(res_vect_valid), int'(e_vv));
    if (e_vv) chk("R12", "vect_vector", int'(res_vect_vector), int'(vec));
    if (e_fault || e_exit)
      chk("R13", "exactly one outcome", int'(res_fault) + int'(res_exit), 1);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2", "held valid", int'(res_valid), 1);
      chk("R2", "held code", int'(res_code), e_code);
      chk("R2", "held exit", int'(res_exit), int'(e_exit));
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R2", "released valid", int'(res_valid), 0);
    chk("R2", "ready after release", int'(req_ready), 1);
    set_default();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset req_ready", int'(req_ready), 1);
    chk("R2", "reset res_valid", int'(res_valid), 0);
  endtask

  task automatic t_direct();
    set_default();
    attempt("R11", 0, 1, 0, 4, 0, 0);
    req_src = 4'd1; req_desc_priv_ok = 0;
    attempt("R5", 1, 0, 13, 1, 0, 0);
    req_gate_present = 0; req_gate_priv_ok = 0;
    attempt("R5", 0, 1, 0, 4, 0, 0);
  endtask

  task automatic t_gate_call();
    set_default(); req_via_gate = 1; req_gate_present = 0; req_gate_priv_ok = 0;
    attempt("R4", 1, 0, 11, 1, 0, 0);
    req_via_gate = 1; req_gate_priv_ok = 0;
    attempt("R4", 1, 0, 13, 1, 0, 0);
    req_via_gate = 1; req_src = 4'd1; req_desc_priv_ok = 0;
    attempt("R4", 0, 1, 0, 4, 0, 0);
  endtask

  task automatic t_soft_sources();
    set_default(); req_src = 4'd2; req_vector = 8'h41;
    attempt("R12", 0, 1, 0, 4, 1, 0);
    req_src = 4'd3; req_gate_priv_ok = 0; req_vector = 8'h03;
    attempt("R6", 1, 0, 13, 1, 1, 0);
    req_src = 4'd4; req_gate_priv_ok = 0; req_vector = 8'h04;
    attempt("R6", 1, 0, 13, 1, 1, 0);
  endtask

  task automatic t_hw_sources();
    set_default(); req_src = 4'd5; req_gate_priv_ok = 0; req_desc_priv_ok = 0;
    req_vector = 8'h02;
    attempt("R6", 0, 1, 0, 4, 1, 0);
    req_src = 4'd6; req_gate_present = 0; req_vector = 8'h0d;
    attempt("R6", 1, 0, 11, 1, 1, 0);
    req_src = 4'd7; req_gate_priv_ok = 0; req_vector = 8'h80;
    attempt("R6", 0, 1, 0, 4, 1, 0);
  endtask

  task automatic t_iret();
    set_default(); req_src = 4'd8; req_nested = 1;
    req_gate_priv_ok = 0; req_desc_priv_ok = 0; req_gate_present = 0;
    attempt("R7", 0, 1, 0, 4, 0, 0);
    req_src = 4'd8; req_nested = 0;
    attempt("R7", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_long();
    set_default(); req_long_mode = 1;
    attempt("R3", 1, 0, 13, 1, 0, 0);
    req_long_mode = 1; req_src = 4'd5;
    attempt("R3", 1, 0, 13, 1, 1, 0);
    req_long_mode = 1; req_src = 4'd8; req_nested = 1;
    attempt("R3", 1, 0, 13, 1, 0, 0);
    req_long_mode = 1; req_src = 4'd8; req_nested = 0;
    attempt("R7", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_selector();
    set_default(); req_sel_in_limit = 0;
    attempt("R8", 1, 0, 13, 2, 0, 0);
    req_sel_in_limit = 0; req_read_pf = 1;
    attempt("R8", 1, 0, 13, 2, 0, 0);
  endtask

  task automatic t_read();
    set_default(); req_read_pf = 1;
    attempt("R9", 1, 0, 14, 3, 0, 0);
    req_read_pf = 1; req_type_ok = 0; req_desc_present = 0;
    attempt("R9", 1, 0, 14, 3, 0, 0);
  endtask

  task automatic t_attr();
    set_default(); req_type_ok = 0; req_desc_present = 0;
    attempt("R10", 1, 0, 13, 4, 0, 0);
    req_desc_present = 0; req_sys_ok = 0;
    attempt("R10", 1, 0, 11, 4, 0, 0);
    req_sys_ok = 0;
    attempt("R10", 1, 0, 13, 4, 0, 0);
    req_limit_ok = 0;
    attempt("R10", 1, 0, 13, 4, 0, 0);
  endtask

  task automatic t_backpressure();
    set_default(); req_read_pf = 1;
    attempt("R2", 1, 0, 14, 3, 0, 3);
    attempt("R2", 0, 1, 0, 4, 0, 2);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    set_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_gate_call();
    t_soft_sources();
    t_hw_sources();
    t_iret();
    t_long();
    t_selector();
    t_read();
    t_attr();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule